// File: doc/BRIEF.md
# Power Control Register with Low-Power Mode Sequencing

This block is a one-byte control register on a simple processor register bus, decoded at address 87h. It holds four stored fields: a baud-rate doubler for serial port 0, a select that changes the meaning of the top bit of each serial control register, and two general-purpose software flags. These fields drive static control outputs toward the serial ports or are simply read back.

Two further bit positions, STOP (bit 1) and IDLE (bit 0), are write-only mode requests. A write that sets either bit moves a small sequencer into idle or stop mode, and that mode holds until the wake input is pulsed. Setting both bits in one write selects stop mode. A write that sets STOP also sends a one-cycle strobe that clears the clock-mode bit held in another register. Bits 5 and 4 belong to oscillator-fail logic kept in a separate block, so this block stores nothing there.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After a synchronous reset, every stored field is 0, `rd_data` at address 87h is 00h, and `idle_req`, `stop_req`, `clkmode_clr`, `baud_x2` and `frame_err_sel` are all 0.
- R2: A write (`wr_en`=1) at address 87h stores bits 7, 6, 3 and 2 of `wr_data`, and they read back at the same positions. Writes to any other address, and cycles with `wr_en`=0, leave the stored fields unchanged.
- R3: Reads at 87h always return 0 in bits 1, 0, 5 and 4. Reads at any other address return 00h.
- R4: A write at 87h with bit 0 = 1 and bit 1 = 0, made while in run mode, raises `idle_req` from the next cycle on. It stays high until wake.
- R5: A write at 87h with bit 1 = 1 raises `stop_req` from the next cycle on. It stays high until wake.
- R6: A write with both bit 1 and bit 0 set gives `stop_req`=1 and `idle_req`=0.
- R7: Each write at 87h with bit 1 = 1 produces `clkmode_clr` high for exactly the one following cycle. A write without bit 1 produces no strobe.
- R8: `baud_x2` follows stored bit 7 and `frame_err_sel` follows stored bit 6.
- R9: A cycle with `wake`=1 leaves both requests low in the next cycle. Wake takes priority over a mode write made in the same cycle.
- R10: `idle_req` and `stop_req` are never high together. An IDLE write made during stop mode leaves stop mode in place, and a STOP write made during idle mode moves to stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the addressed register (combinational) |
| wake | input | 1 | Wake pulse from interrupt or reset logic |
| idle_req | output | 1 | Idle mode request |
| stop_req | output | 1 | Stop mode request |
| clkmode_clr | output | 1 | One-cycle strobe that clears the external clock-mode bit |
| baud_x2 | output | 1 | Serial port 0 baud doubler enable |
| frame_err_sel | output | 1 | Serial control top bit reports framing error when 1 |

## Verification
The bench writes both mode bits together and expects stop mode only. A design that let IDLE win, or that raised both requests, fails here. It writes IDLE while stopped and STOP while idle, which catches a sequencer that drops out of stop mode or refuses to escalate. It pulses wake in the same cycle as a STOP write: wake must win, but the clock-mode strobe must still appear, so a design with the wrong priority, or that gates the strobe with wake, shows a wrong output. It also reads the mode bits back after writing ones, checks writes to a neighbouring address and writes with the strobe low, and watches the strobe for exactly one cycle, which catches leaked storage and a strobe that stretches.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int DATA_W  = 8;
    localparam int B_BAUD  = 7;
    localparam int B_FESEL = 6;
    localparam int B_GF1   = 3;
    localparam int B_GF0   = 2;
    localparam int B_STOP  = 1;
    localparam int B_IDLE  = 0;

    typedef struct packed {
        logic baud_x2;
        logic fe_sel;
        logic gf1;
        logic gf0;
    } pwr_fields_t;

    typedef struct packed {
        logic stop;
        logic idle;
    } mode_req_t;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_STOP = 2'd2
    } pwr_mode_e;

    function automatic pwr_fields_t byte_to_fields(input logic [DATA_W-1:0] b);
        pwr_fields_t f;
        f.baud_x2 = b[B_BAUD];
        f.fe_sel  = b[B_FESEL];
        f.gf1     = b[B_GF1];
        f.gf0     = b[B_GF0];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] fields_to_byte(input pwr_fields_t f);
        logic [DATA_W-1:0] b;
        b          = '0;
        b[B_BAUD]  = f.baud_x2;
        b[B_FESEL] = f.fe_sel;
        b[B_GF1]   = f.gf1;
        b[B_GF0]   = f.gf0;
        return b;
    endfunction

    // Wake wins; stop outranks idle; idle is entered only from run.
    function automatic pwr_mode_e next_mode(input pwr_mode_e cur, input logic hit,
                                            input mode_req_t req, input logic wake);
        if (wake)
            return MODE_RUN;
        if (hit && req.stop)
            return MODE_STOP;
        if (hit && req.idle && cur == MODE_RUN)
            return MODE_IDLE;
        return cur;
    endfunction

endpackage

// File: rtl/pwr_field_regs.sv
module pwr_field_regs
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [DATA_W-1:0] wdata,
    output pwr_fields_t       fields
);

    always_ff @(posedge clk) begin
        if (rst)
            fields <= '0;
        else if (hit)
            fields <= byte_to_fields(wdata);
    end

    AST_BAUD_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit |=> fields.baud_x2 == $past(wdata[B_BAUD])); // R8
    AST_FESEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit |=> fields.fe_sel == $past(wdata[B_FESEL])); // R8
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(fields)); // R2

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  mode_req_t req,
    input  logic      wake,
    output logic      idle_req,
    output logic      stop_req,
    output logic      clkmode_clr
);

    pwr_mode_e mode_q;
    pwr_mode_e mode_d;

    always_comb mode_d = next_mode(mode_q, hit, req, wake);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_RUN;
            clkmode_clr <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            clkmode_clr <= hit && req.stop;
        end
    end

    assign idle_req = (mode_q == MODE_IDLE);
    assign stop_req = (mode_q == MODE_STOP);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(idle_req && stop_req)); // R10
    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wake |=> (!idle_req && !stop_req)); // R9
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (hit && req.stop && !wake) |=> stop_req); // R6
    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (hit && req.idle && !req.stop && !wake && !idle_req && !stop_req) |=> idle_req); // R4
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !wake) |=> stop_req); // R5
    AST_CLR_WITH_STOP: assert property (@(posedge clk) disable iff (rst)
        (clkmode_clr && !$past(wake)) |-> stop_req); // R7

endmodule

// File: rtl/pwr_readback.sv
module pwr_readback
    import pwr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h87
) (
    input  logic [ADDR_W-1:0] addr,
    input  pwr_fields_t       fields,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    always_comb begin
        if (addr == MATCH)
            rdata = fields_to_byte(fields);
        else
            rdata = '0;
    end

endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
    import pwr_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wake,
    output logic              idle_req,
    output logic              stop_req,
    output logic              clkmode_clr,
    output logic              baud_x2,
    output logic              frame_err_sel
);

    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    logic        hit;
    mode_req_t   req;
    pwr_fields_t fields;
    logic        unused_osc_bits;

    assign hit             = wr_en && (bus_addr == MATCH);
    assign req.stop        = wr_data[B_STOP];
    assign req.idle        = wr_data[B_IDLE];
    assign unused_osc_bits = ^wr_data[5:4];

    pwr_field_regs u_fields (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .wdata  (wr_data),
        .fields (fields)
    );

    pwr_mode_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .req         (req),
        .wake        (wake),
        .idle_req    (idle_req),
        .stop_req    (stop_req),
        .clkmode_clr (clkmode_clr)
    );

    pwr_readback #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_rd (
        .addr   (bus_addr),
        .fields (fields),
        .rdata  (rd_data)
    );

    assign baud_x2       = fields.baud_x2;
    assign frame_err_sel = fields.fe_sel;

endmodule

// File: tb/pwr_ctl_reg_tb.sv
module pwr_ctl_reg_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       wake;
    logic       idle_req, stop_req, clkmode_clr, baud_x2, frame_err_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_ctl_reg u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .wake(wake),
        .idle_req(idle_req), .stop_req(stop_req), .clkmode_clr(clkmode_clr),
        .baud_x2(baud_x2), .frame_err_sel(frame_err_sel)
    );

    // {addr, wdata, wake, exp_rd, exp_idle, exp_stop, exp_clr, exp_x2, exp_fe}
    localparam int NV = 13;
    localparam logic [29:0] VEC [NV] = '{
        {8'h87, 8'hCC, 1'b0, 8'hCC, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'h87, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h86, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h87, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h87, 8'h82, 1'b0, 8'h80, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'h87, 8'h01, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'h87, 8'h04, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h87, 8'h4B, 1'b0, 8'h48, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h87, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h87, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h87, 8'h02, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h87, 8'h03, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h88, 8'h02, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one bus cycle, then park the bus on a read of 87h and sample.
    task automatic step(input logic [7:0] a, input logic we, input logic [7:0] d, input logic wk);
        @(negedge clk);
        bus_addr = a; wr_en = we; wr_data = d; wake = wk;
        @(negedge clk);
        bus_addr = 8'h87; wr_en = 1'b0; wr_data = 8'h00; wake = 1'b0;
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_addr = 8'h87; wr_en = 1'b0; wr_data = 8'h00; wake = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 requests", {6'b0, idle_req, stop_req}, 8'h00);
        chk("R1 clkmode_clr", {7'b0, clkmode_clr}, 8'h00);
        chk("R1 static outs", {6'b0, baud_x2, frame_err_sel}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            step(v[29:22], 1'b1, v[21:14], v[13]);
            chk("R2/R3 rd_data", rd_data, v[12:5]);
            chk("R4 idle_req", {7'b0, idle_req}, {7'b0, v[4]});
            chk("R5 stop_req", {7'b0, stop_req}, {7'b0, v[3]});
            chk("R7 clkmode_clr", {7'b0, clkmode_clr}, {7'b0, v[2]});
            chk("R8 baud_x2", {7'b0, baud_x2}, {7'b0, v[1]});
            chk("R8 frame_err_sel", {7'b0, frame_err_sel}, {7'b0, v[0]});
        end

        // R6: both mode bits in one write select stop only
        step(8'h87, 1'b1, 8'h03, 1'b0);
        chk("R6 idle/stop", {6'b0, idle_req, stop_req}, 8'h01);
        // R7: strobe is gone one cycle later; R5 stop held
        step(8'h87, 1'b0, 8'h00, 1'b0);
        chk("R7 strobe width", {7'b0, clkmode_clr}, 8'h00);
        chk("R5 stop held", {7'b0, stop_req}, 8'h01);
        // R9: wake alone clears
        step(8'h87, 1'b0, 8'h00, 1'b1);
        chk("R9 wake clears", {6'b0, idle_req, stop_req}, 8'h00);
        // R4: idle held across idle cycles, no strobe
        step(8'h87, 1'b1, 8'h01, 1'b0);
        chk("R7 no strobe on idle", {7'b0, clkmode_clr}, 8'h00);
        repeat (4) @(negedge clk);
        #1;
        chk("R4 idle held", {6'b0, idle_req, stop_req}, 8'h02);
        // R10: stop from idle, never both
        step(8'h87, 1'b1, 8'h02, 1'b0);
        chk("R10 escalate", {6'b0, idle_req, stop_req}, 8'h01);
        step(8'h87, 1'b0, 8'h00, 1'b1);
        // R2: wr_en low is ignored
        step(8'h87, 1'b1, 8'hC4, 1'b0);
        step(8'h87, 1'b0, 8'h08, 1'b0);
        chk("R2 no write without wr_en", rd_data, 8'hC4);
        chk("R10 no-write keeps run", {6'b0, idle_req, stop_req}, 8'h00);
        // R3: read of another address
        @(negedge clk);
        bus_addr = 8'h07;
        #1;
        chk("R3 other address read", rd_data, 8'h00);
        // R3: mode and oscillator bits never read back
        step(8'h87, 1'b1, 8'h30, 1'b0);
        chk("R3 bits 5:4 read zero", rd_data, 8'h00);
        // R1: reset mid-run
        step(8'h87, 1'b1, 8'hCE, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset clears fields", rd_data, 8'h00);
        chk("R1 reset clears mode", {6'b0, idle_req, stop_req}, 8'h00);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule